// File: doc/BRIEF.md
# XY-Routed Packet Router

This block is the switching element of a small on-chip message network. The network joins several processing clusters and one central control node. Each router has five ports: one toward its own cluster or node, and up to four toward neighbouring routers on a two-dimensional grid. Every port has two channels running in opposite directions, an incoming one and an outgoing one. Each channel carries a 34-bit flit: two framing bits on top of 32 data bits. Flits cross a channel under a synchronous valid/ready handshake.

A packet begins with a head flit, or is a single-flit packet. The router reads the destination grid coordinates from the low data bits of that flit. It resolves the X coordinate first and the Y coordinate second. When both match the router's own address, the packet is delivered to the local port. When several inputs contend for one output, the output is granted in rotating order. Once granted, the output stays with that input until the packet's last flit has left, so packets never interleave on a link. The router's own coordinates and the set of ports that exist are set by parameters. Edge and corner routers drop the ports they lack.

Top module: `xy_router`

## Requirements
- R1: A flit is 34 bits. Bit 32 marks the first flit of a packet and bit 33 marks the last, giving head = 01, body = 00, tail = 10 and single-flit packet = 11 in bits [33:32]. In a first flit, the destination X sits in data bits [XW-1:0] and the destination Y in bits [XW+YW-1:XW].
- R2: Port numbers are 0 local, 1 east (+X), 2 west (−X), 3 north (+Y) and 4 south (−Y). A first flit whose destination X is greater than the router's X leaves on east, and one whose X is smaller leaves on west, whatever its Y.
- R3: A first flit whose destination X equals the router's X leaves on north when its Y is greater, on south when its Y is smaller, and on local when both coordinates match.
- R4: An input takes a flit in a cycle where its valid and ready are both high, and holds it in a one-entry register. Ready is low while that register is full and not draining. Flits from one input leave in the order they arrived.
- R5: Once an output raises valid, valid and the flit stay unchanged until the cycle in which ready is high.
- R6: After a head flit wins an output, the output carries only that input's flits until its tail flit has passed. Body and tail flits follow the head whatever their data bits hold.
- R7: A single-flit packet releases its output as soon as it has passed.
- R8: Each output grants in rotating order. After it finishes a packet from input k, the search for the next grant starts at input k+1 (mod 5). After reset it starts at input 0.
- R9: For a port whose bit in the port mask is 0, the input never raises ready, the output never raises valid, and flits routed toward it never leave.
- R10: During and after reset every output valid is low, and every enabled input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 5 | Per-port incoming flit valid |
| inReady | output | 5 | Per-port incoming ready |
| inFlit | input | 5×34 | Per-port incoming flit |
| outValid | output | 5 | Per-port outgoing flit valid |
| outReady | input | 5 | Per-port outgoing ready from the neighbour |
| outFlit | output | 5×34 | Per-port outgoing flit |

## Verification
The bench sends a single-flit packet from every input to every destination in a 3×3 grid around a router at (1,1). A router that compared Y before X would send diagonal destinations north or south instead of east or west. An off-by-one comparison would misdirect the neighbouring column or row. Two three-flit packets then race for the local port, and their body flits carry coordinates that point elsewhere. A router that re-routed body flits or dropped the lock early would interleave the two packets or scatter their bodies. Five simultaneous requesters after a primer flit show whether the rotating pointer resumes after the last winner, or whether it restarts at zero or favours a fixed port. A stalled output shows whether valid or data moves before acceptance, or whether a second flit overwrites the held one. A masked instance shows whether a missing port can leak traffic.

// File: rtl/xyr_pkg.sv
package xyr_pkg;

  localparam int NPORT  = 5;
  localparam int PIDW   = 3;
  localparam int DATAW  = 32;
  localparam int FRAMEW = 2;
  localparam int FLITW  = DATAW + FRAMEW;

  // Framing bits: [FLITW-2] = first flit, [FLITW-1] = last flit
  localparam int START_BIT = FLITW - 2;
  localparam int END_BIT   = FLITW - 1;

  typedef enum logic [PIDW-1:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } portE;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NPORT-1:0]           pop;
    logic [NPORT-1:0]           outEn;
    logic [NPORT-1:0][PIDW-1:0] outSel;
  } strobeT;

  function automatic logic [PIDW-1:0] nextIdx(input logic [PIDW-1:0] idx);
    return (int'(idx) == NPORT - 1) ? '0 : idx + 1'b1;
  endfunction

endpackage

// File: rtl/xyr_datapath.sv
module xyr_datapath
  import xyr_pkg::*;
#(
  parameter int unsigned      XW        = 2,
  parameter int unsigned      YW        = 2,
  parameter logic [NPORT-1:0] PORT_MASK = '1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NPORT-1:0]               inValid,
  output logic [NPORT-1:0]               inReady,
  input  logic [NPORT-1:0][FLITW-1:0]    inFlit,
  output logic [NPORT-1:0]               outValid,
  output logic [NPORT-1:0][FLITW-1:0]    outFlit,
  input  strobeT                         strobe,
  output logic [NPORT-1:0]               bufFull,
  output logic [NPORT-1:0][FRAMEW-1:0]   bufFrame,
  output logic [NPORT-1:0][XW+YW-1:0]    bufDest
);

  logic [NPORT-1:0][FLITW-1:0] bufData;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    if (PORT_MASK[i]) begin : g_live
      logic fullQ;
      logic [FLITW-1:0] dataQ;
      logic load;

      assign inReady[i] = ~fullQ | strobe.pop[i];
      assign load       = inValid[i] & inReady[i];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) fullQ <= 1'b0;
        else       fullQ <= load | (fullQ & ~strobe.pop[i]);
      end

      always_ff @(posedge clk) begin
        if (load) dataQ <= inFlit[i];
      end

      assign bufFull[i] = fullQ;
      assign bufData[i] = dataQ;
    end else begin : g_tie
      assign inReady[i] = 1'b0;
      assign bufFull[i] = 1'b0;
      assign bufData[i] = '0;
    end
    assign bufFrame[i] = bufData[i][FLITW-1 -: FRAMEW];
    assign bufDest[i]  = bufData[i][XW+YW-1:0];
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      outValid[o] = strobe.outEn[o];
      outFlit[o]  = '0;
      for (int i = 0; i < NPORT; i++) begin
        if (strobe.outSel[o] == PIDW'(i)) outFlit[o] = bufData[i];
      end
    end
  end

endmodule

// File: rtl/xyr_ctrl.sv
module xyr_ctrl
  import xyr_pkg::*;
#(
  parameter int unsigned      XW        = 2,
  parameter int unsigned      YW        = 2,
  parameter logic [XW-1:0]    MY_X      = XW'(1),
  parameter logic [YW-1:0]    MY_Y      = YW'(1),
  parameter logic [NPORT-1:0] PORT_MASK = '1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NPORT-1:0]             bufFull,
  input  logic [NPORT-1:0][FRAMEW-1:0] bufFrame,
  input  logic [NPORT-1:0][XW+YW-1:0]  bufDest,
  input  logic [NPORT-1:0]             outReady,
  output strobeT                       strobe
);

  localparam int DW = XW + YW;

  logic [NPORT-1:0]             locked;
  logic [NPORT-1:0][PIDW-1:0]   owner;
  logic [NPORT-1:0]             ownsAny;
  logic [NPORT-1:0][PIDW-1:0]   wantPort;
  logic [NPORT-1:0]             wantOk;
  logic [NPORT-1:0][NPORT-1:0]  req;     // [output][input]
  logic [NPORT-1:0]             outEn;
  logic [NPORT-1:0]             ownerEnd;
  logic [NPORT-1:0]             fire;

  // X first, then Y, then local
  function automatic logic [PIDW-1:0] xyRoute(input logic [DW-1:0] d);
    logic [XW-1:0] dx;
    logic [YW-1:0] dy;
    dx = d[XW-1:0];
    dy = d[DW-1:XW];
    if (dx > MY_X)      return PORT_EAST;
    else if (dx < MY_X) return PORT_WEST;
    else if (dy > MY_Y) return PORT_NORTH;
    else if (dy < MY_Y) return PORT_SOUTH;
    else                return PORT_LOCAL;
  endfunction

  // Rotating search from ptr; result = {found, index}
  function automatic logic [PIDW:0] rrPick(input logic [NPORT-1:0] r,
                                           input logic [PIDW-1:0] ptr);
    logic [PIDW:0] res;
    res = '0;
    for (int k = 0; k < NPORT; k++) begin
      int c;
      c = int'(ptr) + k;
      if (c >= NPORT) c = c - NPORT;
      if (!res[PIDW] && r[c]) res = {1'b1, PIDW'(c)};
    end
    return res;
  endfunction

  always_comb begin
    ownsAny = '0;
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        if (locked[o] && owner[o] == PIDW'(i)) ownsAny[i] = 1'b1;
      end
    end

    for (int i = 0; i < NPORT; i++) begin
      wantPort[i] = xyRoute(bufDest[i]);
      wantOk[i]   = bufFull[i] && bufFrame[i][0] && !ownsAny[i];
    end

    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        req[o][i] = wantOk[i] && (wantPort[i] == PIDW'(o)) && PORT_MASK[o];
      end
    end

    for (int o = 0; o < NPORT; o++) begin
      outEn[o]    = 1'b0;
      ownerEnd[o] = 1'b0;
      for (int i = 0; i < NPORT; i++) begin
        if (owner[o] == PIDW'(i)) begin
          outEn[o]    = locked[o] && bufFull[i];
          ownerEnd[o] = bufFrame[i][1];
        end
      end
      fire[o] = outEn[o] && outReady[o];
    end

    strobe.pop = '0;
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        if (fire[o] && owner[o] == PIDW'(i)) strobe.pop[i] = 1'b1;
      end
    end
    strobe.outEn  = outEn;
    strobe.outSel = owner;
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    logic            lockQ;
    logic [PIDW-1:0] ownQ;
    logic [PIDW-1:0] ptrQ;
    logic [PIDW:0]   pick;

    assign pick = rrPick(req[o], ptrQ);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lockQ <= 1'b0;
        ownQ  <= '0;
        ptrQ  <= '0;
      end else if (lockQ) begin
        if (fire[o] && ownerEnd[o]) begin
          lockQ <= 1'b0;
          ptrQ  <= nextIdx(ownQ);
        end
      end else if (pick[PIDW]) begin
        lockQ <= 1'b1;
        ownQ  <= pick[PIDW-1:0];
      end
    end

    assign locked[o] = lockQ;
    assign owner[o]  = ownQ;
  end

endmodule

// File: rtl/xy_router.sv
module xy_router
  import xyr_pkg::*;
#(
  parameter int unsigned      XW        = 2,
  parameter int unsigned      YW        = 2,
  parameter logic [XW-1:0]    MY_X      = XW'(1),
  parameter logic [YW-1:0]    MY_Y      = YW'(1),
  parameter logic [NPORT-1:0] PORT_MASK = '1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NPORT-1:0]          inValid,
  output logic [NPORT-1:0]          inReady,
  input  logic [NPORT-1:0][FLITW-1:0] inFlit,
  output logic [NPORT-1:0]          outValid,
  input  logic [NPORT-1:0]          outReady,
  output logic [NPORT-1:0][FLITW-1:0] outFlit
);

  strobeT                       strobe;
  logic [NPORT-1:0]             bufFull;
  logic [NPORT-1:0][FRAMEW-1:0] bufFrame;
  logic [NPORT-1:0][XW+YW-1:0]  bufDest;

  xyr_datapath #(
    .XW(XW), .YW(YW), .PORT_MASK(PORT_MASK)
  ) u_datapath (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady), .inFlit(inFlit),
    .outValid(outValid), .outFlit(outFlit),
    .strobe(strobe),
    .bufFull(bufFull), .bufFrame(bufFrame), .bufDest(bufDest)
  );

  xyr_ctrl #(
    .XW(XW), .YW(YW), .MY_X(MY_X), .MY_Y(MY_Y), .PORT_MASK(PORT_MASK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .bufFull(bufFull), .bufFrame(bufFrame), .bufDest(bufDest),
    .outReady(outReady),
    .strobe(strobe)
  );

endmodule

// File: rtl/xy_router_chk.sv
module xy_router_chk
  import xyr_pkg::*;
#(
  parameter int unsigned      XW        = 2,
  parameter int unsigned      YW        = 2,
  parameter logic [XW-1:0]    MY_X      = XW'(1),
  parameter logic [YW-1:0]    MY_Y      = YW'(1),
  parameter logic [NPORT-1:0] PORT_MASK = '1
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NPORT-1:0]            outValid,
  input logic [NPORT-1:0]            outReady,
  input logic [NPORT-1:0][FLITW-1:0] outFlit
);

  function automatic int expectPort(input logic [FLITW-1:0] f);
    int dx, dy, mx, my;
    dx = int'(f[XW-1:0]);
    dy = int'(f[XW+YW-1:XW]);
    mx = int'(MY_X);
    my = int'(MY_Y);
    if (dx != mx) return (dx > mx) ? 1 : 2;
    if (dy != my) return (dy > my) ? 3 : 4;
    return 0;
  endfunction

  for (genvar o = 0; o < NPORT; o++) begin : g_port
    logic inPkt;
    logic xfer;
    int   expPort;

    assign xfer    = outValid[o] && outReady[o];
    assign expPort = expectPort(outFlit[o]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) inPkt <= 1'b0;
      else if (xfer) begin
        if (outFlit[o][START_BIT] && !outFlit[o][END_BIT]) inPkt <= 1'b1;
        else if (outFlit[o][END_BIT])                      inPkt <= 1'b0;
      end
    end

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      outValid[o] && !outReady[o] |=> outValid[o] && $stable(outFlit[o]));

    // R6
    frame_order_chk: assert property (@(posedge clk) disable iff (!rstN)
      xfer |-> (outFlit[o][START_BIT] == !inPkt));

    // R2
    route_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
      outValid[o] && outFlit[o][START_BIT] |-> (expPort == o));

    if (!PORT_MASK[o]) begin : g_off
      // R9
      masked_out_chk: assert property (@(posedge clk) disable iff (!rstN)
        !outValid[o]);
    end
  end

endmodule

bind xy_router xy_router_chk #(
  .XW(XW), .YW(YW), .MY_X(MY_X), .MY_Y(MY_Y), .PORT_MASK(PORT_MASK)
) u_chk (
  .clk(clk), .rstN(rstN),
  .outValid(outValid), .outReady(outReady), .outFlit(outFlit)
);

// File: tb/xy_router_tb.sv
`timescale 1ns/1ps
module xy_router_tb;
  import xyr_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN;
  logic [4:0] inValid, inReady, outValid, outReady;
  logic [4:0][33:0] inFlit, outFlit;
  logic [4:0] mInValid, mInReady, mOutValid, mOutReady;
  logic [4:0][33:0] mInFlit, mOutFlit;

  xy_router #(.XW(2), .YW(2), .MY_X(2'd1), .MY_Y(2'd1), .PORT_MASK(5'b11111)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inFlit(inFlit),
    .outValid(outValid), .outReady(outReady), .outFlit(outFlit));

  xy_router #(.XW(2), .YW(2), .MY_X(2'd1), .MY_Y(2'd1), .PORT_MASK(5'b10111)) u_dutMasked (
    .clk(clk), .rstN(rstN), .inValid(mInValid), .inReady(mInReady), .inFlit(mInFlit),
    .outValid(mOutValid), .outReady(mOutReady), .outFlit(mOutFlit));

  int nChecks = 0;
  int nFails  = 0;
  logic [36:0] got[$];

  // Record transfers: valid & ready at negedge means a transfer at the next posedge
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      for (int o = 0; o < 5; o++) begin
        if (outValid[o] && outReady[o]) got.push_back({3'(o), outFlit[o]});
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [33:0] mk(input logic [1:0] fr, input int src,
                                     input int seq, input int dx, input int dy);
    return {fr, 8'(src), 8'(seq), 12'h000, 2'(dy), 2'(dx)};
  endfunction

  // Router at (1,1): X first, then Y, then local
  function automatic int routeOf(input int dx, input int dy);
    if (dx > 1) return 1;
    if (dx < 1) return 2;
    if (dy > 1) return 3;
    if (dy < 1) return 4;
    return 0;
  endfunction

  task automatic send(input int p, input logic [33:0] f);
    @(posedge clk); #1;
    inValid[p] = 1'b1;
    inFlit[p]  = f;
    do @(negedge clk); while (!inReady[p]);
    @(posedge clk); #1;
    inValid[p] = 1'b0;
  endtask

  task automatic sendPkt(input int p);
    send(p, mk(2'b01, p, 0, 1, 1));
    send(p, mk(2'b00, p, 1, 3, 1));
    send(p, mk(2'b10, p, 2, 0, 0));
  endtask

  task automatic expectRec(input string req, input string what,
                           input int port, input logic [33:0] f);
    if (got.size() == 0) check(req, {what, " missing"}, 64'h1, 64'h0);
    else begin
      logic [36:0] r;
      r = got.pop_front();
      check(req, what, 64'(r), 64'({3'(port), f}));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL R4 watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = '0; inFlit = '0; outReady = '1;
    mInValid = '0; mInFlit = '0; mOutReady = '1;
    @(negedge clk);
    check("R10", "valid during reset", 64'(outValid), 64'h0);
    repeat (3) @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    check("R10", "ready after reset", 64'(inReady), 64'h1f);
    check("R10", "valid after reset", 64'(outValid), 64'h0);
    check("R9", "masked ready after reset", 64'(mInReady), 64'h17);

    // R1 framing/dest fields; R2 X-first, R3 Y then local
    for (int i = 0; i < 5; i++) begin
      for (int dx = 0; dx < 3; dx++) begin
        for (int dy = 0; dy < 3; dy++) begin
          send(i, mk(2'b11, i, dx * 3 + dy, dx, dy));
          repeat (6) @(posedge clk);
          @(negedge clk);
          expectRec((dx != 1) ? "R2" : "R3", "route sweep", routeOf(dx, dy),
                    mk(2'b11, i, dx * 3 + dy, dx, dy));
        end
      end
    end
    check("R2", "no stray flits", 64'(got.size()), 64'h0);

    // R6: two 3-flit packets race for local; body carries an east-looking address
    fork
      sendPkt(2);
      sendPkt(3);
    join
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R6", "packet flit count", 64'(got.size()), 64'd6);
    if (got.size() == 6) begin
      logic [36:0] r[6];
      int a, b;
      for (int k = 0; k < 6; k++) r[k] = got.pop_front();
      a = int'(r[0][31:24]);
      check("R6", "first winner is a racer", 64'(a == 2 || a == 3), 64'h1);
      b = 5 - a;
      for (int k = 0; k < 6; k++) begin
        int s, q, ex, ey;
        logic [1:0] fr;
        s  = (k < 3) ? a : b;
        q  = k % 3;
        fr = (q == 0) ? 2'b01 : (q == 1) ? 2'b00 : 2'b10;
        ex = (q == 0) ? 1 : (q == 1) ? 3 : 0;
        ey = (q == 0) ? 1 : (q == 1) ? 1 : 0;
        check("R6", "locked packet order", 64'(r[k]), 64'({3'd0, mk(fr, s, q, ex, ey)}));
      end
    end

    // R8 primer: input 3 finishes a packet on local -> pointer at 4
    send(3, mk(2'b11, 3, 0, 1, 1));
    repeat (6) @(posedge clk);
    @(negedge clk);
    expectRec("R8", "primer", 0, mk(2'b11, 3, 0, 1, 1));

    // R8 / R7: five single-flit packets to local, expect 4,0,1,2,3
    fork
      send(0, mk(2'b11, 0, 1, 1, 1));
      send(1, mk(2'b11, 1, 1, 1, 1));
      send(2, mk(2'b11, 2, 1, 1, 1));
      send(3, mk(2'b11, 3, 1, 1, 1));
      send(4, mk(2'b11, 4, 1, 1, 1));
    join
    repeat (20) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      int s;
      s = (4 + k) % 5;
      expectRec((k == 0) ? "R8" : "R7", "rotating order", 0, mk(2'b11, s, 1, 1, 1));
    end

    // R4 / R5: stall the local output
    @(posedge clk); #1 outReady[0] = 1'b0;
    send(1, mk(2'b11, 1, 7, 1, 1));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R5", "valid held under stall", 64'(outValid[0]), 64'h1);
    check("R5", "flit held under stall", 64'(outFlit[0]), 64'(mk(2'b11, 1, 7, 1, 1)));
    @(posedge clk); #1;
    inValid[1] = 1'b1;
    inFlit[1]  = mk(2'b11, 1, 8, 1, 1);
    @(negedge clk);
    check("R4", "ready low while buffer full", 64'(inReady[1]), 64'h0);
    repeat (3) @(negedge clk);
    check("R5", "flit still held", 64'(outFlit[0]), 64'(mk(2'b11, 1, 7, 1, 1)));
    @(posedge clk); #1 outReady[0] = 1'b1;
    do @(negedge clk); while (!inReady[1]);
    @(posedge clk); #1 inValid[1] = 1'b0;
    repeat (8) @(posedge clk);
    @(negedge clk);
    expectRec("R4", "stalled flit first", 0, mk(2'b11, 1, 7, 1, 1));
    expectRec("R4", "second flit after", 0, mk(2'b11, 1, 8, 1, 1));
    check("R4", "no extra flits", 64'(got.size()), 64'h0);

    // R9: masked north port on the second instance
    begin
      int seen;
      seen = 0;
      @(posedge clk); #1;
      mInValid[3] = 1'b1; mInFlit[3] = mk(2'b11, 3, 0, 1, 1);
      mInValid[2] = 1'b1; mInFlit[2] = mk(2'b11, 2, 0, 1, 2);
      @(posedge clk); #1 mInValid[2] = 1'b0;
      repeat (8) begin
        @(negedge clk);
        if (mOutValid != 5'h0) seen++;
      end
      check("R9", "masked input ready", 64'(mInReady[3]), 64'h0);
      check("R9", "no output from masked traffic", 64'(seen), 64'h0);
      mInValid[3] = 1'b0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule